// File: doc/BRIEF.md
# Fluorescent Display Grid Scanner with Key Matrix Capture

This block multiplexes a vacuum fluorescent display. It lights one grid at a time. For each lit grid it reads that grid's 24-bit word from display memory and puts the word on the segment pins. A short dark gap follows every grid slot. This gap stops one grid's pattern from bleeding into the next.

After the last grid, the block runs a key-scan pass. Each of the sixteen low segment pins is driven high alone, in turn. On every step the two key-return inputs are sampled, which reads a 16×2 switch matrix. The 32 sampled bits are held in a shadow register. They are copied to the visible key word in one step when the pass completes, so a reader never sees a half-updated word.

The eight high segment pins are shared with grids 12 down to 5. How many of them act as grids depends on the grid count set for the frame. Display memory is read through a combinational port: the word must be valid in the same cycle as its address.

Top module: `vfd_scan_seq`

## Requirements
- R1: While reset is held: key word is 0, change flag is 0, read address is 0, and only dedicated grid pin 0 is high (grid 1 is lit).
- R2: A frame lights grids 1..N in order. Grid g (0-based) reads memory address g and stays lit for `cfg_on_ticks` cycles, with 0 treated as 1. The key-scan pass follows the last grid's gap, and grid 1 of the next frame follows the key-scan pass.
- R3: After every grid slot, including the last one, there are `cfg_gap_ticks` cycles with every segment pin and every grid pin low. A value of 0 removes the gap.
- R4: While grid g is lit, `seg_pin[15:0]` equals bits 15:0 of memory word g.
- R5: Shared pin `seg_pin[16+j]` (j = 0..7) belongs to grid 12-j when N ≥ 12-j. In that case it is high only while that grid is lit. Otherwise it carries bit 16+j of the lit grid's word.
- R6: `grid_pin[i]` (i = 0..3) is high only while grid i+1 is lit.
- R7: N is `cfg_grids` limited to the range 4..12. It is sampled under reset and again when a new frame starts. A change in the middle of a frame takes effect from the next frame.
- R8: The key-scan pass has 16 steps, each KEY_STEP cycles long. In step s, `seg_pin` is exactly `1<<s` and all grid pins are low. At the last cycle of step s, `key_ret[0]` is captured as key bit 2s and `key_ret[1]` as key bit 2s+1.
- R9: `key_word` changes only once per frame, in the cycle after the key-scan pass ends. All 32 bits change together.
- R10: `key_changed` is set when the newly latched word differs from the word it replaces. It keeps that value until the next latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_grids | input | 4 | Requested grid count, limited to 4..12 |
| cfg_on_ticks | input | ON_W | Lit cycles per grid slot (0 acts as 1) |
| cfg_gap_ticks | input | GAP_W | Dark cycles after each grid slot |
| rd_addr | output | 4 | Display memory address (the lit grid's index) |
| rd_word | input | 24 | Display memory word, valid in the same cycle as its address |
| seg_pin | output | 24 | Segment pins; the low 16 are key sources and the high 8 are shared with grids 12..5 |
| grid_pin | output | 4 | Dedicated grid pins 1..4 |
| key_ret | input | 2 | Key-return inputs from the matrix |
| key_word | output | 32 | Latched key matrix word; bit 2s+k is return k on source s |
| key_changed | output | 1 | Set when the last latch changed the key word |

## Verification
The bench drives the grid count into both clamp limits and changes it in the middle of a frame. A design that does not clamp would read a missing memory word or skip dedicated grids. A design that does not hold N for the frame would cut a frame short or stretch it.

It uses a zero lit time and a zero gap. An off-by-one in either case would add or drop a cycle, and that shift would move every slot after it. It also sweeps the grid count so that each shared pin is used both as a grid and as a segment. A wrong pin mapping would then light a grid from data bits or drop a segment.

The key patterns include a press on the last source, the same pattern twice, and a release to all zeros. These catch a design that latches before the final sample, or whose change flag sticks or compares against the wrong word.

// File: rtl/vfd_seq_pkg.sv
// Shared constants and the phase type for the grid scanner.
// Assumes the fixed pin arrangement: 24 segments, 4 dedicated grids, 8 shared pins.
package vfd_seq_pkg;
    localparam int SEG_N     = 24;
    localparam int SHARED_N  = 8;
    localparam int KEY_SRC_N = 16;
    localparam int KEY_RET_N = 2;
    localparam int KEY_BITS  = KEY_SRC_N * KEY_RET_N;
    localparam int GRID_MIN  = 4;
    localparam int GRID_MAX  = 12;
    localparam int DEDIC_N   = 4;
    localparam int IDX_W     = 4;

    typedef enum logic [1:0] {
        PH_LIT = 2'd0,
        PH_GAP = 2'd1,
        PH_KEY = 2'd2
    } phase_t;

    // Limit a requested grid count to the supported range.
    function automatic logic [IDX_W-1:0] clamp_grids(input logic [IDX_W-1:0] req);
        if (req < IDX_W'(GRID_MIN))      return IDX_W'(GRID_MIN);
        else if (req > IDX_W'(GRID_MAX)) return IDX_W'(GRID_MAX);
        else                             return req;
    endfunction
endpackage

// File: rtl/vfd_slot_timer.sv
// Frame sequencer: steps through lit slots, dark gaps and key-scan steps.
// Assumes cfg_on_ticks and cfg_gap_ticks are held steady within a slot.
// The grid count is captured under reset and when each frame starts.
module vfd_slot_timer
    import vfd_seq_pkg::*;
#(
    parameter int ON_W     = 16,
    parameter int GAP_W    = 8,
    parameter int KEY_STEP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   cfg_grids,
    input  logic [ON_W-1:0]    cfg_on_ticks,
    input  logic [GAP_W-1:0]   cfg_gap_ticks,
    output phase_t             phase,
    output logic [IDX_W-1:0]   idx,
    output logic [IDX_W-1:0]   n_act,
    output logic               sample_en,
    output logic               last_src
);
    localparam int CNT_W = (ON_W > GAP_W) ? ON_W : GAP_W;
    localparam logic [CNT_W-1:0] STEP_LIM = CNT_W'(KEY_STEP - 1);
    localparam logic [IDX_W-1:0] SRC_LAST = IDX_W'(KEY_SRC_N - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] on_lim;
    logic [CNT_W-1:0] gap_lim;
    logic             on_done, gap_done, step_done, grid_last;

    // Slot end detection for each phase.
    always_comb begin
        on_lim    = (cfg_on_ticks == '0) ? '0 : CNT_W'(cfg_on_ticks - ON_W'(1));
        gap_lim   = CNT_W'(cfg_gap_ticks) - CNT_W'(1);
        on_done   = (cnt >= on_lim);
        gap_done  = (cfg_gap_ticks == '0) || (cnt >= gap_lim);
        step_done = (cnt >= STEP_LIM);
        grid_last = (idx == IDX_W'(n_act - IDX_W'(1)));
        sample_en = (phase == PH_KEY) && step_done;
        last_src  = (idx == SRC_LAST);
    end

    // Phase, index and tick counter state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_LIT;
            idx   <= '0;
            cnt   <= '0;
            n_act <= clamp_grids(cfg_grids);
        end else begin
            case (phase)
                PH_LIT: begin
                    if (on_done) begin
                        cnt <= '0;
                        if (cfg_gap_ticks != '0) begin
                            phase <= PH_GAP;
                        end else if (grid_last) begin
                            phase <= PH_KEY;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_GAP: begin
                    if (gap_done) begin
                        cnt <= '0;
                        if (grid_last) begin
                            phase <= PH_KEY;
                            idx   <= '0;
                        end else begin
                            phase <= PH_LIT;
                            idx   <= idx + IDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_KEY: begin
                    if (step_done) begin
                        cnt <= '0;
                        if (last_src) begin
                            phase <= PH_LIT;
                            idx   <= '0;
                            n_act <= clamp_grids(cfg_grids);
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    phase <= PH_LIT;
                    idx   <= '0;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R7: the active grid count always lies within the supported range.
    a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (n_act >= IDX_W'(GRID_MIN)) && (n_act <= IDX_W'(GRID_MAX)));

    // R7: the grid count only moves when the key-scan pass hands over to a new frame.
    a_r7_count_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_KEY) |=> $stable(n_act));

    // R2: outside the key-scan pass the index never passes the last active grid.
    a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_KEY) |-> (idx < n_act));
endmodule

// File: rtl/vfd_pin_mux.sv
// Maps sequencer state and the memory word onto segment and grid pins.
// Assumes rd_word belongs to the lit grid's address in the same cycle.
module vfd_pin_mux
    import vfd_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  phase_t             phase,
    input  logic [IDX_W-1:0]   idx,
    input  logic [IDX_W-1:0]   n_act,
    input  logic [SEG_N-1:0]   rd_word,
    output logic [SEG_N-1:0]   seg_pin,
    output logic [DEDIC_N-1:0] grid_pin
);
    localparam int LOW_N = SEG_N - SHARED_N;

    logic lit, scan;

    // Phase decode shared by all pins.
    always_comb begin
        lit  = (phase == PH_LIT);
        scan = (phase == PH_KEY);
    end

    genvar p;
    generate
        for (p = 0; p < LOW_N; p++) begin : g_low
            // Low segments: data while lit, key source during the scan pass.
            always_comb seg_pin[p] = lit ? rd_word[p] : (scan && (idx == IDX_W'(p)));
        end
        for (p = 0; p < SHARED_N; p++) begin : g_shared
            localparam logic [IDX_W-1:0] OWN_GRID = IDX_W'(GRID_MAX - 1 - p);
            // Shared pin: grid drive when its grid is in use, segment data otherwise.
            always_comb begin
                if (!lit)                  seg_pin[LOW_N+p] = 1'b0;
                else if (OWN_GRID < n_act) seg_pin[LOW_N+p] = (idx == OWN_GRID);
                else                       seg_pin[LOW_N+p] = rd_word[LOW_N+p];
            end
        end
        for (p = 0; p < DEDIC_N; p++) begin : g_dedic
            // Dedicated grid pin: high while its own grid is lit.
            always_comb grid_pin[p] = lit && (idx == IDX_W'(p));
        end
    endgenerate

    // R6: at most one dedicated grid pin is high at a time.
    a_r6_grid_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid_pin));

    // R8: a scan step drives exactly one pin and lights no grid.
    a_r8_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_KEY) |-> (($countones(seg_pin) == 1) && (grid_pin == '0)));
endmodule

// File: rtl/vfd_key_latch.sv
// Collects key-return samples in a shadow register and publishes them
// once per frame, together with a flag that shows whether the word changed.
// Assumes key_ret is synchronous to clk.
module vfd_key_latch
    import vfd_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic                 last_src,
    input  logic [IDX_W-1:0]     src_idx,
    input  logic [KEY_RET_N-1:0] key_ret,
    output logic [KEY_BITS-1:0]  key_word,
    output logic                 key_changed
);
    logic [KEY_BITS-1:0] shadow;
    logic [KEY_BITS-1:0] fresh;

    // Shadow contents with the current step's sample merged in.
    always_comb begin
        fresh = shadow;
        fresh[int'(src_idx)*KEY_RET_N +: KEY_RET_N] = key_ret;
    end

    // Store each sample; publish the whole word after the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow      <= '0;
            key_word    <= '0;
            key_changed <= 1'b0;
        end else if (sample_en) begin
            shadow <= fresh;
            if (last_src) begin
                key_word    <= fresh;
                key_changed <= (fresh != key_word);
            end
        end
    end

    // R9: the visible word holds except right after the final scan sample.
    a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_en && last_src) |=> $stable(key_word));

    // R10: after a latch the flag reports whether the word moved.
    a_r10_flag_meaning: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && last_src) |=> (key_changed == (key_word != $past(key_word))));
endmodule

// File: rtl/vfd_scan_seq.sv
// Top of the display grid scanner with key-matrix capture.
// Assumes a combinational display memory read port.
module vfd_scan_seq
    import vfd_seq_pkg::*;
#(
    parameter int ON_W     = 16,
    parameter int GAP_W    = 8,
    parameter int KEY_STEP = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           cfg_grids,
    input  logic [ON_W-1:0]      cfg_on_ticks,
    input  logic [GAP_W-1:0]     cfg_gap_ticks,
    output logic [3:0]           rd_addr,
    input  logic [23:0]          rd_word,
    output logic [23:0]          seg_pin,
    output logic [3:0]           grid_pin,
    input  logic [1:0]           key_ret,
    output logic [31:0]          key_word,
    output logic                 key_changed
);
    phase_t           phase;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] n_act;
    logic             sample_en;
    logic             last_src;

    // Memory address follows the slot index.
    always_comb rd_addr = idx;

    vfd_slot_timer #(
        .ON_W     (ON_W),
        .GAP_W    (GAP_W),
        .KEY_STEP (KEY_STEP)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_grids     (cfg_grids),
        .cfg_on_ticks  (cfg_on_ticks),
        .cfg_gap_ticks (cfg_gap_ticks),
        .phase         (phase),
        .idx           (idx),
        .n_act         (n_act),
        .sample_en     (sample_en),
        .last_src      (last_src)
    );

    vfd_pin_mux u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .idx      (idx),
        .n_act    (n_act),
        .rd_word  (rd_word),
        .seg_pin  (seg_pin),
        .grid_pin (grid_pin)
    );

    vfd_key_latch u_keys (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en   (sample_en),
        .last_src    (last_src),
        .src_idx     (idx),
        .key_ret     (key_ret),
        .key_word    (key_word),
        .key_changed (key_changed)
    );
endmodule

// File: tb/vfd_scan_seq_test.sv
// Scoreboard bench: the driver task queues the expected pin pattern of each
// frame, and the monitor checks it cycle by cycle at the falling edge.
module vfd_scan_seq_test;
    localparam int KEY_STEP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_grids = 4'd5;
    logic [15:0] cfg_on_ticks = 16'd1;
    logic [7:0]  cfg_gap_ticks = 8'd0;
    logic [3:0]  rd_addr;
    logic [23:0] rd_word;
    logic [23:0] seg_pin;
    logic [3:0]  grid_pin;
    logic [1:0]  key_ret;
    logic [31:0] key_word;
    logic        key_changed;

    logic [23:0] mem [16];
    logic [31:0] pressed = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct packed {
        logic [23:0] seg;
        logic [3:0]  grid;
        logic [15:0] len;
        logic [31:0] kw;
        logic        kc;
        logic [3:0]  req;
    } item_t;

    item_t q[$];
    logic [31:0] prev_kw = '0;
    logic        prev_kc = 1'b0;
    int          frame_no = 0;

    always #10 clk = ~clk;

    vfd_scan_seq #(.ON_W(16), .GAP_W(8), .KEY_STEP(KEY_STEP)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_grids     (cfg_grids),
        .cfg_on_ticks  (cfg_on_ticks),
        .cfg_gap_ticks (cfg_gap_ticks),
        .rd_addr       (rd_addr),
        .rd_word       (rd_word),
        .seg_pin       (seg_pin),
        .grid_pin      (grid_pin),
        .key_ret       (key_ret),
        .key_word      (key_word),
        .key_changed   (key_changed)
    );

    assign rd_word = mem[rd_addr];

    // Switch matrix model: return k sees source s when key bit 2s+k is pressed.
    always_comb begin
        key_ret = 2'b00;
        for (int s = 0; s < 16; s++) begin
            if (seg_pin[s] && pressed[2*s])   key_ret[0] = 1'b1;
            if (seg_pin[s] && pressed[2*s+1]) key_ret[1] = 1'b1;
        end
    end

    task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    // Queue one frame of expected pin activity and set its stimulus.
    task automatic frame(input int gc, input int on, input int gap,
                         input logic [31:0] prs, input int late_gc);
        int n;
        int st;
        item_t it;
        if (rst_n) wait (q.size() == 0);
        n  = (gc < 4) ? 4 : ((gc > 12) ? 12 : gc);      // R7 clamp
        st = (on == 0) ? 1 : on;                           // R2 zero acts as one
        frame_no++;
        cfg_grids     = 4'(gc);
        cfg_on_ticks  = 16'(on);
        cfg_gap_ticks = 8'(gap);
        for (int g = 0; g < 16; g++)
            mem[g] = 24'hA5C396 ^ (24'(g) * 24'h011111) ^ (24'(frame_no) * 24'h13579B);
        for (int g = 0; g < n; g++) begin
            it = '0;
            it.kw = prev_kw; it.kc = prev_kc;
            for (int p = 0; p < 16; p++) it.seg[p] = mem[g][p];   // R4
            for (int p = 16; p < 24; p++) begin                   // R5 shared pins
                if (27 - p < n) it.seg[p] = (27 - p == g);
                else            it.seg[p] = mem[g][p];
            end
            it.grid = (g < 4) ? 4'(1 << g) : 4'd0;                // R6
            it.len = 16'(st); it.req = 4'd2;                      // R2 slot order/length
            q.push_back(it);
            if (gap > 0) begin                                    // R3 dark gap
                it.seg = '0; it.grid = '0; it.len = 16'(gap); it.req = 4'd3;
                q.push_back(it);
            end
        end
        for (int s = 0; s < 16; s++) begin                        // R8 scan steps
            it.seg = 24'(1 << s); it.grid = '0; it.len = 16'(KEY_STEP); it.req = 4'd8;
            q.push_back(it);
        end
        prev_kc = (prs != prev_kw);                               // R10
        prev_kw = prs;                                            // R9
        @(negedge clk);
        pressed = prs;
        if (late_gc >= 0) cfg_grids = 4'(late_gc);                // R7 mid-frame change
    endtask

    // Monitor: compare outputs with the head of the queue each cycle.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (rst_n && q.size() > 0) begin
                it = q[0];
                check(seg_pin == it.seg, int'(it.req), 32'(seg_pin), 32'(it.seg));
                check(grid_pin == it.grid, int'(it.req), 32'(grid_pin), 32'(it.grid));
                check(key_word == it.kw, 9, key_word, it.kw);             // R9
                check(key_changed == it.kc, 10, 32'(key_changed), 32'(it.kc)); // R10
                if (it.len <= 16'd1) void'(q.pop_front());
                else q[0].len = it.len - 16'd1;
            end
        end
    end

    // Driver.
    initial begin
        frame(5, 3, 2, 32'h0000_0001, -1);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(key_word == '0, 1, key_word, 32'h0);
        check(key_changed == 1'b0, 1, 32'(key_changed), 32'h0);
        check(rd_addr == 4'd0, 1, 32'(rd_addr), 32'h0);
        check(grid_pin == 4'b0001, 1, 32'(grid_pin), 32'h1);
        @(posedge clk);
        #1 rst_n = 1'b1;
        frame(12, 2, 0, 32'hC000_0003, -1);
        frame(2, 0, 1, 32'hC000_0003, 12);   // unchanged keys; late grid count ignored
        frame(12, 1, 3, 32'h5A5A_A5A5, -1);
        frame(15, 2, 1, 32'h0000_0000, -1);
        frame(8, 1, 0, 32'h0000_0000, -1);
        frame(9, 1, 2, 32'h8000_0000, -1);
        wait (q.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R2 watchdog: actual=stalled expected=frames complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule